// File: doc/BRIEF.md
# Unaligned Access Byte-Mask Splitter

This block sits between a processor's memory stage and a longword-wide system bus. It takes one processor request at a time: a 30-bit physical byte address, an access size (byte, word or longword), a direction flag and write data. It turns that request into one or two bus requests. Each bus request carries only a longword address and a per-lane byte-enable mask. The two low address bits never reach the bus. Instead they shape the mask, so a device behind the bus sees exactly the bytes the processor asked for and no others. This matters for device registers where a read has side effects.

An access that fits inside one longword produces a single bus request. An access that runs past a longword boundary produces two requests to consecutive longwords. Each of the two carries a partial mask. For writes, the operand is rotated onto the byte lanes its mask enables. For reads, the returned longwords are shifted and merged back into a right-justified operand, and the result goes back on a response channel.

All data-carrying edges use valid/ready. The processor request is taken when `creq_valid` and `creq_ready` are both high at a clock edge. A bus request stays valid with stable fields until `breq_ready` is seen. A bus response is taken when `bresp_valid` and `bresp_ready` meet. The processor response holds its data until `cresp_ready` is seen.

Top module: `bms_splitter`

## Requirements
- R1: A bus request address is bits 29:2 of the processor address (28 bits). Bits 1:0 appear only through the mask, and every issued mask has at least one bit set. Mask bit i enables byte lane i, which is data bits 8i+7:8i.
- R2: A longword access (size code 2) whose address bits 1:0 are 00 gives exactly one bus request with mask 1111.
- R3: A word access (size code 1) with address bits 1:0 equal to 00, 01 or 10 gives one request with mask 0011, 0110 or 1100 respectively.
- R4: A byte access (size code 0) gives one request whose mask has the single bit selected by address bits 1:0 (0001, 0010, 0100, 1000).
- R5: An access that crosses a longword boundary gives two requests, strictly in order. The first goes to bits 29:2 and the second to that value plus one, wrapping modulo 2^28.
- R6: A longword access with address bits 1:0 of 01, 10 or 11 uses first masks 1110, 1100 or 1000 and second masks 0001, 0011 or 0111.
- R7: A word access with address bits 1:0 equal to 11 is split into mask 1000 at the first longword and mask 0001 at the next.
- R8: A read result is right-justified. Operand byte k comes from the byte enabled by the (k+1)-th set mask bit, counting the first request's mask from lane 0 and then the second's. Result bytes beyond the access size are zero.
- R9: Write data is rotated left by 8 times address bits 1:0. Lanes that overflow past lane 3 go out with the second request, and every lane whose mask bit is clear carries zero.
- R10: `creq_ready` stays low from the acceptance of a request until its processor response has been taken.
- R11: `cresp_valid` rises in the cycle after the last bus response is taken and holds with stable data until `cresp_ready`. The response data for a write is zero. A bus request holds its fields stable while it is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| creq_valid | input | 1 | Processor request valid |
| creq_ready | output | 1 | Block can take a processor request |
| creq_addr | input | 30 | Physical byte address |
| creq_size | input | 2 | 0 byte, 1 word, 2 longword (3 treated as longword) |
| creq_write | input | 1 | 1 write, 0 read |
| creq_wdata | input | 32 | Right-justified write operand |
| breq_valid | output | 1 | Bus request valid |
| breq_ready | input | 1 | Bus takes the request |
| breq_addr | output | 28 | Longword address |
| breq_mask | output | 4 | Byte-lane enables |
| breq_write | output | 1 | Bus request direction |
| breq_wdata | output | 32 | Lane-steered write data |
| bresp_valid | input | 1 | Bus response valid |
| bresp_ready | output | 1 | Block takes the bus response |
| bresp_rdata | input | 32 | Returned longword |
| cresp_valid | output | 1 | Processor response valid |
| cresp_ready | input | 1 | Processor takes the response |
| cresp_rdata | output | 32 | Merged read operand, zero for writes |

## Verification
After a processor request is taken, the first bus request is valid in the following cycle. Each response is accepted in the cycle it arrives, and the processor response is due exactly one cycle after the last bus response is taken. So an unsplit access can finish no earlier than the third edge after acceptance, and a split one no earlier than the fifth. The bench stalls both bus channels and the processor response in varied patterns. It compares each bus request with its scoreboard entry at the edge where the handshake occurs, rather than at a fixed latency. It then samples `cresp_valid` on the half cycle after the last bus response, which tests the one-cycle rule directly.

// File: rtl/bms_pkg.sv
package bms_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ1,
    ST_RSP1,
    ST_REQ2,
    ST_RSP2,
    ST_DONE
  } seq_state_e;

  // Number of operand bytes for a size code, capped at the bus width.
  function automatic int size_bytes(input logic [1:0] sz, input int lanes);
    int n;
    n = 1 << sz;
    if (n > lanes) n = lanes;
    return n;
  endfunction

endpackage

// File: rtl/bms_lane_plan.sv
// Derives the two byte-enable masks and lane-steered write words for one access.
module bms_lane_plan
  import bms_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int DW    = 8 * LANES,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  input  logic [DW-1:0]    wdata,
  output logic [LANES-1:0] mask_lo,
  output logic [LANES-1:0] mask_hi,
  output logic [DW-1:0]    wdata_lo,
  output logic [DW-1:0]    wdata_hi,
  output logic             split
);

  int                 nbytes;
  logic [LANES-1:0]   base;
  logic [DW-1:0]      wd_trim;
  logic [2*LANES-1:0] span;
  logic [2*DW-1:0]    wide;

  assign nbytes = size_bytes(size, LANES);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign base[g]            = (g < nbytes);
      assign wd_trim[8*g +: 8]  = base[g] ? wdata[8*g +: 8] : 8'h00;
    end
  endgenerate

  // Shift the contiguous enable run and the trimmed operand into a two-longword window.
  assign span = {{LANES{1'b0}}, base} << off;
  assign wide = {{DW{1'b0}}, wd_trim} << {off, 3'b000};

  assign mask_lo  = span[LANES-1:0];
  assign mask_hi  = span[2*LANES-1:LANES];
  assign wdata_lo = wide[DW-1:0];
  assign wdata_hi = wide[2*DW-1:DW];
  assign split    = |mask_hi;

  always_comb begin
    assert_mask_count_R6: assert ($countones({mask_hi, mask_lo}) == nbytes);
    assert_first_nonempty_R1: assert (mask_lo != '0);
  end

endmodule

// File: rtl/bms_read_merge.sv
// Re-assembles a right-justified operand from one or two returned longwords.
module bms_read_merge
  import bms_pkg::*;
#(
  parameter  int LANES = 4,
  localparam int DW    = 8 * LANES,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  input  logic [DW-1:0]    rd_lo,
  input  logic [DW-1:0]    rd_hi,
  output logic [DW-1:0]    result
);

  int             nbytes;
  logic [2*DW-1:0] pair;
  logic [2*DW-1:0] aligned;

  assign nbytes  = size_bytes(size, LANES);
  assign pair    = {rd_hi, rd_lo};
  assign aligned = pair >> {off, 3'b000};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_keep
      assign result[8*g +: 8] = (g < nbytes) ? aligned[8*g +: 8] : 8'h00;
    end
  endgenerate

endmodule

// File: rtl/bms_splitter.sv
module bms_splitter
  import bms_pkg::*;
#(
  parameter  int ADDR_W = 30,
  parameter  int LANES  = 4,
  localparam int DW     = 8 * LANES,
  localparam int OFF_W  = $clog2(LANES),
  localparam int LA_W   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              creq_valid,
  output logic              creq_ready,
  input  logic [ADDR_W-1:0] creq_addr,
  input  logic [1:0]        creq_size,
  input  logic              creq_write,
  input  logic [DW-1:0]     creq_wdata,
  output logic              breq_valid,
  input  logic              breq_ready,
  output logic [LA_W-1:0]   breq_addr,
  output logic [LANES-1:0]  breq_mask,
  output logic              breq_write,
  output logic [DW-1:0]     breq_wdata,
  input  logic              bresp_valid,
  output logic              bresp_ready,
  input  logic [DW-1:0]     bresp_rdata,
  output logic              cresp_valid,
  input  logic              cresp_ready,
  output logic [DW-1:0]     cresp_rdata
);

  seq_state_e       state;
  logic [LA_W-1:0]  lw_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       size_q;
  logic             wr_q;
  logic             split_q;
  logic [LANES-1:0] m_lo_q, m_hi_q;
  logic [DW-1:0]    wd_lo_q, wd_hi_q;
  logic [DW-1:0]    rd_lo_q;
  logic [DW-1:0]    result_q;

  logic [LANES-1:0] pl_m_lo, pl_m_hi;
  logic [DW-1:0]    pl_wd_lo, pl_wd_hi;
  logic             pl_split;
  logic [DW-1:0]    merge_lo, merge_hi, merged;

  bms_lane_plan #(.LANES(LANES)) u_plan (
    .off      (creq_addr[OFF_W-1:0]),
    .size     (creq_size),
    .wdata    (creq_wdata),
    .mask_lo  (pl_m_lo),
    .mask_hi  (pl_m_hi),
    .wdata_lo (pl_wd_lo),
    .wdata_hi (pl_wd_hi),
    .split    (pl_split)
  );

  // The response in flight feeds the merge directly so the result registers in the same edge.
  assign merge_lo = (state == ST_RSP1) ? bresp_rdata : rd_lo_q;
  assign merge_hi = (state == ST_RSP2) ? bresp_rdata : '0;

  bms_read_merge #(.LANES(LANES)) u_merge (
    .off    (off_q),
    .size   (size_q),
    .rd_lo  (merge_lo),
    .rd_hi  (merge_hi),
    .result (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lw_q     <= '0;
      off_q    <= '0;
      size_q   <= '0;
      wr_q     <= 1'b0;
      split_q  <= 1'b0;
      m_lo_q   <= '0;
      m_hi_q   <= '0;
      wd_lo_q  <= '0;
      wd_hi_q  <= '0;
      rd_lo_q  <= '0;
      result_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (creq_valid) begin
          lw_q    <= creq_addr[ADDR_W-1:OFF_W];
          off_q   <= creq_addr[OFF_W-1:0];
          size_q  <= creq_size;
          wr_q    <= creq_write;
          split_q <= pl_split;
          m_lo_q  <= pl_m_lo;
          m_hi_q  <= pl_m_hi;
          wd_lo_q <= creq_write ? pl_wd_lo : '0;
          wd_hi_q <= creq_write ? pl_wd_hi : '0;
          state   <= ST_REQ1;
        end
        ST_REQ1: if (breq_ready) state <= ST_RSP1;
        ST_RSP1: if (bresp_valid) begin
          rd_lo_q <= bresp_rdata;
          if (split_q) begin
            state <= ST_REQ2;
          end else begin
            result_q <= wr_q ? '0 : merged;
            state    <= ST_DONE;
          end
        end
        ST_REQ2: if (breq_ready) state <= ST_RSP2;
        ST_RSP2: if (bresp_valid) begin
          result_q <= wr_q ? '0 : merged;
          state    <= ST_DONE;
        end
        ST_DONE: if (cresp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign creq_ready  = (state == ST_IDLE);
  assign breq_valid  = (state == ST_REQ1) || (state == ST_REQ2);
  assign breq_addr   = (state == ST_REQ2) ? lw_q + 1'b1 : lw_q;
  assign breq_mask   = (state == ST_REQ2) ? m_hi_q : m_lo_q;
  assign breq_wdata  = (state == ST_REQ2) ? wd_hi_q : wd_lo_q;
  assign breq_write  = wr_q;
  assign bresp_ready = (state == ST_RSP1) || (state == ST_RSP2);
  assign cresp_valid = (state == ST_DONE);
  assign cresp_rdata = result_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (breq_valid && !breq_ready) |=>
      (breq_valid && $stable(breq_addr) && $stable(breq_mask) && $stable(breq_wdata)));

  assert_resp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cresp_valid && !cresp_ready) |=> (cresp_valid && $stable(cresp_rdata)));

  assert_single_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    creq_ready |-> !(breq_valid || bresp_ready || cresp_valid));

  assert_accept_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (creq_valid && creq_ready) |=> !creq_ready);

  assert_write_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cresp_valid && wr_q) |-> (cresp_rdata == '0));

  assert_mask_present_R1: assert property (@(posedge clk) disable iff (!rst_n)
    breq_valid |-> (breq_mask != '0));

endmodule

// File: tb/sim_bms_splitter.sv
module sim_bms_splitter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        creq_valid = 1'b0;
  logic        creq_ready;
  logic [29:0] creq_addr = '0;
  logic [1:0]  creq_size = '0;
  logic        creq_write = 1'b0;
  logic [31:0] creq_wdata = '0;
  logic        breq_valid;
  logic        breq_ready = 1'b0;
  logic [27:0] breq_addr;
  logic [3:0]  breq_mask;
  logic        breq_write;
  logic [31:0] breq_wdata;
  logic        bresp_valid = 1'b0;
  logic        bresp_ready;
  logic [31:0] bresp_rdata = '0;
  logic        cresp_valid;
  logic        cresp_ready = 1'b0;
  logic [31:0] cresp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  bms_splitter u0 (.*);

  typedef struct {
    logic [27:0] addr;
    logic [3:0]  mask;
    logic        wr;
    logic [31:0] wdata;
    bit          last;
    string       atag;
    string       tag;
  } bexp_t;

  typedef struct {
    logic [31:0] data;
    string       tag;
  } cexp_t;

  bexp_t bq[$];
  cexp_t cq[$];

  int          n_run = 0, n_fail = 0, cyc = 0, busy_viol = 0, rsp_wait = 0;
  bit          busy = 0, rsp_hs = 0, pend_last = 0, done_due = 0;
  logic [31:0] pend_data = '0;

  function automatic logic [31:0] pat(input logic [27:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h40, ~a[7:0], a[7:0] ^ 8'hC3};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Bus responder and scoreboard monitors, all acting on the falling edge.
  always @(negedge clk) if (rst_n) begin
    bexp_t e;
    cexp_t c;
    cyc++;
    if (done_due) begin
      check(cresp_valid == 1'b1, "R11", "cresp_valid one cycle after last bus response",
            64'(cresp_valid), 64'd1);
      done_due = 0;
    end
    if (rsp_hs) begin
      bresp_valid = 1'b0;
      rsp_hs = 0;
    end
    if (rsp_wait > 0) begin
      rsp_wait--;
      if (rsp_wait == 0) begin
        bresp_valid = 1'b1;
        bresp_rdata = pend_data;
      end
    end
    if (bresp_valid && bresp_ready) begin
      rsp_hs = 1;
      if (pend_last) done_due = 1;
    end
    breq_ready = (cyc % 3 != 0);
    if (breq_valid && breq_ready) begin
      if (bq.size() == 0) begin
        check(0, "R5", "unexpected bus request", 64'(breq_addr), 64'd0);
      end else begin
        e = bq.pop_front();
        check(breq_addr == e.addr, e.atag, "bus address", 64'(breq_addr), 64'(e.addr));
        check(breq_mask == e.mask, e.tag, "byte mask", 64'(breq_mask), 64'(e.mask));
        check(breq_write == e.wr, e.tag, "direction", 64'(breq_write), 64'(e.wr));
        if (e.wr)
          check(breq_wdata == e.wdata, "R9", "lane data", 64'(breq_wdata), 64'(e.wdata));
        pend_data = pat(breq_addr);
        pend_last = e.last;
        rsp_wait  = 1 + (cyc % 2);
      end
    end
    if (busy && creq_ready) busy_viol++;
    cresp_ready = (cyc % 4 != 1);
    if (cresp_valid && cresp_ready) begin
      if (cq.size() == 0) begin
        check(0, "R11", "unexpected processor response", 64'(cresp_rdata), 64'd0);
      end else begin
        c = cq.pop_front();
        check(cresp_rdata == c.data, c.tag, "result data", 64'(cresp_rdata), 64'(c.data));
      end
      busy = 0;
    end
  end

  task automatic do_acc(input logic [29:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input string tag);
    int          nb, off;
    logic [3:0]  m [2];
    logic [31:0] d [2];
    logic [27:0] la [2];
    logic [31:0] res, rw;
    bexp_t       e;
    cexp_t       c;
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    off = int'(a[1:0]);
    la[0] = a[29:2];
    la[1] = a[29:2] + 28'd1;
    m[0] = '0; m[1] = '0; d[0] = '0; d[1] = '0; res = '0;
    for (int i = 0; i < nb; i++) begin
      int p, w, l;
      p = off + i;
      w = p / 4;
      l = p % 4;
      m[w][l] = 1'b1;
      d[w][8*l +: 8] = wd[8*i +: 8];
      rw = pat(la[w]);
      res[8*i +: 8] = rw[8*l +: 8];
    end
    e.addr = la[0]; e.mask = m[0]; e.wr = wr; e.wdata = d[0];
    e.last = (m[1] == 4'b0); e.atag = "R1"; e.tag = tag;
    bq.push_back(e);
    if (m[1] != 4'b0) begin
      e.addr = la[1]; e.mask = m[1]; e.wdata = d[1]; e.last = 1; e.atag = "R5";
      bq.push_back(e);
    end
    c.data = wr ? 32'h0 : res;
    c.tag  = wr ? "R11" : "R8";
    cq.push_back(c);
    @(negedge clk);
    creq_addr  = a;
    creq_size  = sz;
    creq_write = wr;
    creq_wdata = wd;
    creq_valid = 1'b1;
    while (!creq_ready) @(negedge clk);
    @(negedge clk);
    busy = 1;
    creq_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(creq_ready == 1'b1, "R10", "reset creq_ready", 64'(creq_ready), 64'd1);
    check(breq_valid == 1'b0, "R1", "reset breq_valid", 64'(breq_valid), 64'd0);
    check(cresp_valid == 1'b0, "R11", "reset cresp_valid", 64'(cresp_valid), 64'd0);
    rst_n = 1'b1;

    do_acc(30'h0000_0100, 2'd2, 1'b0, '0, "R2");
    do_acc(30'h0000_0201, 2'd2, 1'b0, '0, "R6");
    do_acc(30'h0000_0302, 2'd2, 1'b0, '0, "R6");
    do_acc(30'h0000_0403, 2'd2, 1'b0, '0, "R6");
    do_acc(30'h0000_0500, 2'd1, 1'b0, '0, "R3");
    do_acc(30'h0000_0601, 2'd1, 1'b0, '0, "R3");
    do_acc(30'h0000_0702, 2'd1, 1'b0, '0, "R3");
    do_acc(30'h0000_0803, 2'd1, 1'b0, '0, "R7");
    for (int k = 0; k < 4; k++)
      do_acc(30'h0000_0900 + 30'(k), 2'd0, 1'b0, '0, "R4");
    do_acc(30'h3FFF_FFFF, 2'd2, 1'b0, '0, "R5");
    do_acc(30'h0000_1000, 2'd2, 1'b1, 32'hDEAD_BEEF, "R2");
    do_acc(30'h0000_1101, 2'd2, 1'b1, 32'h1122_3344, "R6");
    do_acc(30'h0000_1203, 2'd2, 1'b1, 32'hA1B2_C3D4, "R6");
    do_acc(30'h0000_1303, 2'd1, 1'b1, 32'hFFFF_5AA5, "R7");
    do_acc(30'h0000_1401, 2'd1, 1'b1, 32'h0000_BEEF, "R3");
    do_acc(30'h0000_1502, 2'd0, 1'b1, 32'h1234_5677, "R4");
    do_acc(30'h3FFF_FFFE, 2'd2, 1'b1, 32'hCAFE_F00D, "R5");

    while (bq.size() != 0 || cq.size() != 0 || busy) @(negedge clk);
    check(busy_viol == 0, "R10", "creq_ready raised while busy", 64'(busy_viol), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule